// File: doc/BRIEF.md
# Edge-Triggered DMA Request Acceptor

This block sits between an external active-low DMA request line and one DMA channel that performs single-address transfers. It looks for falling edges on the line, but not with a plain edge detector. Acceptance is open only while the channel is enabled and has transfers left. A low level seen in that window is captured as a held request and offered to the channel arbiter. When the arbiter grants the bus, the held request is cleared and the single transfer cycle runs, with the acknowledge output driven low.

During the cycle the block looks for the line to return high. It re-opens acceptance only when two things are true: the single cycle has ended, and a high level has been observed. A line that stays low therefore cannot start a second transfer. A transfer counter is loaded from outside and counts completed cycles. When the last cycle completes, it raises a one-cycle end pulse and acceptance closes.

The request line passes through a synchronizer before any decision is made. Its delay is part of the minimum gap between the line falling and the bus being handed over.

Top module: `dma_edge_req_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the block resets so that req_pending is 0, ack_n is 1 and transfer_end is 0.
- R2: The request line passes through SYNC_STAGES (default 2) flops. A low level first present at rising edge k produces req_pending = 1 after edge k+2, provided acceptance is open. Acceptance is open when enable is 1 and the transfer count is nonzero.
- R3: A held request stays asserted until bus_grant is sampled 1. At that edge req_pending drops to 0 and ack_n goes to 0.
- R4: ack_n stays 0 from the activation edge through the edge at which dma_cycle_done is sampled 1, and returns to 1 after that edge. dma_cycle_done has no effect outside a cycle.
- R5: A synchronized high level sampled during the cycle, including at the edge that ends it, re-opens acceptance right after the cycle. A following low level is then accepted.
- R6: If no high level was sampled during the cycle, acceptance stays closed until a synchronized high is sampled. A line held low starts no second transfer.
- R7: When enable is 0, or the count is zero, at a rising edge, a held request is dropped. A cycle already under way still runs to completion.
- R8: Each completed cycle decrements the count. The cycle that takes the count from 1 to 0 makes transfer_end 1 for exactly one clock after its ending edge. After that, no low level is accepted until the count is reloaded.
- R9: ack_n falls only in the clock after one in which req_pending was 1. req_pending and ack_n = 0 are never seen together.
- R10: cnt_load loads cnt_value into the count and takes priority over a decrement at the same edge. In that case no end pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n_pin | input | 1 | External active-low request line, asynchronous |
| enable | input | 1 | Channel transfer-enable bit |
| bus_grant | input | 1 | Arbiter grants the bus to the held request |
| dma_cycle_done | input | 1 | Current single transfer cycle ends at this edge |
| cnt_load | input | 1 | Load the transfer count |
| cnt_value | input | CNT_W | Value loaded into the count |
| req_pending | output | 1 | Held request offered to the arbiter |
| ack_n | output | 1 | Active-low acknowledge during the single cycle |
| transfer_end | output | 1 | One-cycle pulse after the final transfer |

## Verification
The hardest situation to reach is a request line that is still low when a single cycle ends. The block must then sit in its re-arm wait and refuse further transfers until the line goes high. The directed part holds the line low across a whole cycle and for many cycles afterwards, then releases it and drives it low again. A long pseudo-random phase then varies the line with sticky levels so that releases land before, during and exactly at the ending edge. Throughout, all three outputs are compared against a behavioural model on every clock.

// File: rtl/dmaq_pkg.sv
// Shared types for the DMA request acceptor.
// Assumes: no other package defines these names.
package dmaq_pkg;
    // Acceptance states: open for a low level, request held, transfer cycle, waiting for high
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HELD  = 2'd1,
        ST_XFER  = 2'd2,
        ST_REARM = 2'd3
    } acc_state_t;
endpackage

// File: rtl/dmaq_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2. All stages reset to RESET_VAL.
module dmaq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Move the value one stage along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dmaq_count.sv
// Transfer counter. It is loadable, decrements once per completed cycle,
// and pulses an end flag when the final cycle completes.
// Assumes: dec is a one-cycle strobe. A load wins over dec at the same edge.
module dmaq_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             nonzero,
    output logic             end_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Count register: load has priority, decrement saturates at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (load)                    cnt <= load_val;
        else if (dec && (cnt != '0))      cnt <= cnt - ONE;
    end

    // End flag: one clock after the cycle that empties the count
    always_ff @(posedge clk) begin
        if (!rst_n) end_pulse <= 1'b0;
        else        end_pulse <= dec && (cnt == ONE) && !load;
    end

    assign nonzero = (cnt != '0);
endmodule

// File: rtl/dmaq_fsm.sv
// Accept / hold / transfer / re-arm sequencer for a falling-edge request.
// Assumes: pin_low is already synchronized, and grant and done are clocked inputs.
module dmaq_fsm
    import dmaq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       pin_low,
    input  logic       grant,
    input  logic       done,
    output acc_state_t state,
    output logic       pending,
    output logic       ack_n,
    output logic       dec
);
    acc_state_t nxt;
    logic       hi_seen;

    // Next-state decision for the acceptance sequence
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPEN:  if (run && pin_low) nxt = ST_HELD;
            ST_HELD:  if (!run)           nxt = ST_OPEN;
                      else if (grant)     nxt = ST_XFER;
            ST_XFER:  if (done) begin
                          if (!run || hi_seen || !pin_low) nxt = ST_OPEN;
                          else                             nxt = ST_REARM;
                      end
            ST_REARM: if (!run || !pin_low) nxt = ST_OPEN;
            default:  nxt = ST_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= nxt;
    end

    // Remember whether the line was seen high during the current cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_seen <= 1'b0;
        else if (state == ST_HELD)           hi_seen <= 1'b0;
        else if (state == ST_XFER && !pin_low) hi_seen <= 1'b1;
    end

    assign pending = (state == ST_HELD);
    assign ack_n   = (state != ST_XFER);
    assign dec     = (state == ST_XFER) && done;
endmodule

// File: rtl/dma_edge_req_ctrl.sv
// Top of the edge-triggered DMA request acceptor for one single-address channel.
// Assumes: req_n_pin is asynchronous and all other inputs are synchronous to clk.
module dma_edge_req_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n_pin,
    input  logic             enable,
    input  logic             bus_grant,
    input  logic             dma_cycle_done,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    output logic             req_pending,
    output logic             ack_n,
    output logic             transfer_end
);
    import dmaq_pkg::*;

    logic       pin_sync;
    logic       cnt_nonzero;
    logic       run;
    logic       dec;
    acc_state_t state;

    dmaq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_n_pin),
        .q     (pin_sync)
    );

    dmaq_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (cnt_value),
        .dec       (dec),
        .nonzero   (cnt_nonzero),
        .end_pulse (transfer_end)
    );

    assign run = enable && cnt_nonzero;

    dmaq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pin_low (!pin_sync),
        .grant   (bus_grant),
        .done    (dma_cycle_done),
        .state   (state),
        .pending (req_pending),
        .ack_n   (ack_n),
        .dec     (dec)
    );
endmodule

// File: rtl/dmaq_checker.sv
// Protocol checker for dma_edge_req_ctrl, attached by bind.
module dmaq_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic bus_grant,
    input logic dma_cycle_done,
    input logic req_pending,
    input logic ack_n,
    input logic transfer_end
);
    // R3: a granted request is cleared and the cycle starts
    a_r3_grant_starts: assert property (@(posedge clk) disable iff (!rst_n)
        req_pending && bus_grant && run |=> !req_pending && !ack_n);

    // R3: an ungranted request stays held while acceptance is allowed
    a_r3_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        req_pending && !bus_grant && run |=> req_pending);

    // R4: the cycle continues until done
    a_r4_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n && !dma_cycle_done |=> !ack_n);

    // R4: done ends the cycle
    a_r4_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n && dma_cycle_done |=> ack_n);

    // R7: no held request survives a closed window
    a_r7_drop_held: assert property (@(posedge clk) disable iff (!rst_n)
        !run && ack_n |=> !req_pending);

    // R8: the end flag lasts one clock
    a_r8_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        transfer_end |=> !transfer_end);

    // R9: a cycle starts only from a held request
    a_r9_ack_from_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(req_pending));

    // R9: held request and acknowledge are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_pending && !ack_n));
endmodule

bind dma_edge_req_ctrl dmaq_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run            (run),
    .bus_grant      (bus_grant),
    .dma_cycle_done (dma_cycle_done),
    .req_pending    (req_pending),
    .ack_n          (ack_n),
    .transfer_end   (transfer_end)
);

// File: tb/sim_dma_edge_req_ctrl.sv
module sim_dma_edge_req_ctrl;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_n_pin = 1'b1;
    logic             enable = 1'b0;
    logic             bus_grant = 1'b0;
    logic             dma_cycle_done = 1'b0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic             req_pending, ack_n, transfer_end;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_edge_req_ctrl #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u0 (
        .clk, .rst_n, .req_n_pin, .enable, .bus_grant, .dma_cycle_done,
        .cnt_load, .cnt_value, .req_pending, .ack_n, .transfer_end
    );

    // Behavioural model: 0 open, 1 held, 2 cycle, 3 waiting for high
    bit     m_p1 = 1, m_p2 = 1;
    int     m_st = 0;
    int     m_cnt = 0;
    bit     m_hi = 0;
    bit     m_end = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1 = 1; m_p2 = 1; m_st = 0; m_cnt = 0; m_hi = 0; m_end = 0;
        end else begin
            bit run, low, nend;
            int nst, ncnt;
            run  = enable && (m_cnt != 0);
            low  = !m_p2;
            nst  = m_st;
            ncnt = m_cnt;
            nend = 0;
            case (m_st)
                0: if (run && low) nst = 1;
                1: if (!run) nst = 0; else if (bus_grant) begin nst = 2; m_hi = 0; end
                2: begin
                    if (dma_cycle_done) begin
                        nst = (!run || m_hi || !low) ? 0 : 3;
                        if (m_cnt != 0) ncnt = m_cnt - 1;
                        if (m_cnt == 1 && !cnt_load) nend = 1;
                    end else if (!low) m_hi = 1;
                end
                default: if (!run || !low) nst = 0;
            endcase
            if (cnt_load) ncnt = int'(cnt_value);
            m_st = nst; m_cnt = ncnt; m_end = nend;
            m_p2 = m_p1; m_p1 = req_n_pin;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", "req_pending vs model", req_pending, m_st == 1);
            chk("R4", "ack_n vs model", ack_n, m_st != 2);
            chk("R8", "transfer_end vs model", transfer_end, m_end);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic grant_once();
        bus_grant = 1; tick(1); bus_grant = 0;
    endtask

    task automatic finish_cycle(input int len);
        tick(len); dma_cycle_done = 1; tick(1); dma_cycle_done = 0;
    endtask

    initial begin : watchdog
        #700000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset values
        chk("R1", "req_pending in reset", req_pending, 1'b0);
        chk("R1", "ack_n in reset", ack_n, 1'b1);
        chk("R1", "transfer_end in reset", transfer_end, 1'b0);
        rst_n = 1; tick(1);

        // R2: nothing accepted while disabled
        req_n_pin = 0; tick(6);
        chk("R2", "no acceptance while disabled", req_pending, 1'b0);
        req_n_pin = 1; tick(4);

        // R2: latency through the synchronizer
        cnt_load = 1; cnt_value = 3; enable = 1; tick(1); cnt_load = 0;
        req_n_pin = 0; tick(2);
        chk("R2", "not pending before third edge", req_pending, 1'b0);
        tick(1);
        chk("R2", "pending after third edge", req_pending, 1'b1);

        // R3: held without grant, cleared by grant
        tick(4);
        chk("R3", "held while no grant", req_pending, 1'b1);
        grant_once();
        chk("R3", "cleared on grant", req_pending, 1'b0);
        chk("R9", "ack only after held request", ack_n, 1'b0);

        // R4 and R6: line stays low through the cycle
        tick(2);
        chk("R4", "ack held during cycle", ack_n, 1'b0);
        finish_cycle(0);
        chk("R4", "ack released after done", ack_n, 1'b1);
        tick(10);
        chk("R6", "held-low line gives no second request", req_pending, 1'b0);
        chk("R6", "held-low line gives no second cycle", ack_n, 1'b1);

        // R5: release then new falling edge
        req_n_pin = 1; tick(4); req_n_pin = 0; tick(3);
        chk("R5", "new edge accepted after re-arm", req_pending, 1'b1);
        grant_once();
        req_n_pin = 1; tick(3); req_n_pin = 0;
        finish_cycle(0);
        tick(3);
        chk("R5", "high seen in cycle re-opens at once", req_pending, 1'b1);

        // R8: last transfer ends the count
        grant_once(); req_n_pin = 1;
        finish_cycle(1);
        chk("R8", "end pulse after final cycle", transfer_end, 1'b1);
        tick(1);
        chk("R8", "end pulse one clock only", transfer_end, 1'b0);
        req_n_pin = 0; tick(6);
        chk("R8", "no acceptance at zero count", req_pending, 1'b0);

        // R7: disable drops held request
        req_n_pin = 1; cnt_load = 1; cnt_value = 2; tick(1); cnt_load = 0;
        tick(3); req_n_pin = 0; tick(4);
        chk("R7", "held before disable", req_pending, 1'b1);
        enable = 0; tick(1);
        chk("R7", "dropped on disable", req_pending, 1'b0);
        enable = 1; tick(1);

        // R10: load beats decrement at the same edge
        tick(2); grant_once(); req_n_pin = 1;
        tick(1); cnt_load = 1; cnt_value = 1; dma_cycle_done = 1; tick(1);
        cnt_load = 0; dma_cycle_done = 0;
        chk("R10", "no end pulse when load wins", transfer_end, 1'b0);
        req_n_pin = 0; tick(4); grant_once(); finish_cycle(0);
        chk("R10", "reloaded count of one ends after one cycle", transfer_end, 1'b1);

        // Pseudo-random phase checked against the model every clock
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) req_n_pin = ~req_n_pin;
            bus_grant      = ($urandom_range(0, 2) == 0);
            dma_cycle_done = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 60) == 0) enable = ~enable;
            cnt_load = ($urandom_range(0, 40) == 0);
            cnt_value = CNT_W'($urandom_range(0, 5));
            tick(1);
        end
        cnt_load = 0; bus_grant = 0; dma_cycle_done = 0;
        tick(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule